// File: doc/BRIEF.md
# Link Blocking Aggregator

This block gathers every reason a PCIe port may have for holding its link out of service and reduces them to two states. The local state is blocked whenever any local source asks for it: the Link Disable control bit (honoured only when the port is the upstream side of its link), a software disable/re-enable request that latches until released, or any bit of a vector of custom blocking conditions. The global state is blocked when either the local side or the link partner is blocking.

Both states live in a small four-state machine whose state encodes the pair (local, partner): `LS_OPEN` (neither blocks), `LS_REMOTE` (only the partner blocks), `LS_LOCAL` (only this side blocks) and `LS_BOTH`. Every cycle the machine moves to the state named by the freshly combined local request and the sampled partner input: `LS_OPEN->LS_LOCAL` and `LS_REMOTE->LS_BOTH` on a new local request, `LS_LOCAL->LS_OPEN` and `LS_BOTH->LS_REMOTE` on its release, and the matching partner-driven moves between `LS_OPEN/LS_REMOTE` and `LS_LOCAL/LS_BOTH`; any pair of changes in one cycle is taken as a single jump. A second two-state machine, `API_RUN` and `API_HELD`, holds the software disable. When the local state changes and the port is function 0, a one-cycle strobe tells the partner. While the global state is blocked, training attempts are refused and an established link is asked to go down.

Top module: `link_block_agg`

## Requirements
- R1: While and right after reset, local_block, global_block, partner_notify, link_down_req and train_fail are 0, training_allowed is 1, and the software disable is released (local_block stays 0 with all sources idle).
- R2: If any bit of custom_block is 1 at a clock edge, local_block is 1 after that edge; it returns to 0 after the first edge at which no source is blocking.
- R3: link_disable counts as a local blocking source only when is_upstream is 1 at the same edge; with is_upstream 0 it has no effect on local_block.
- R4: A 1 on api_disable at an edge latches the software disable (local_block is 1 after that edge, whatever is_upstream is); it stays latched until an edge with api_enable 1 and api_disable 0; with both at 1 the disable wins.
- R5: After each edge, global_block equals the local blocking request at that edge OR partner_block sampled at that edge.
- R6: partner_notify is 1 for exactly the cycle after an edge at which local_block changes value, and only if func_num was 0 at that edge; otherwise it is 0.
- R7: link_down_req equals global_block AND link_up, without a register, so it rises in the same cycle as global_block when link_up is high.
- R8: training_allowed is the inverse of global_block, and train_fail equals train_req AND global_block, both without a register.
- R9: A change of partner_block alone changes global_block but never raises partner_notify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_upstream | input | 1 | 1 when this port is the upstream component of the link |
| func_num | input | FN_W | Function number; only function 0 notifies the partner |
| link_disable | input | 1 | Link Disable bit of the link control register |
| api_disable | input | 1 | Software request to disable the link (latched) |
| api_enable | input | 1 | Software request to re-enable the link |
| custom_block | input | NB | Custom blocking conditions, one per bit |
| partner_block | input | 1 | Local blocked state reported by the link partner |
| link_up | input | 1 | 1 while the link is trained |
| train_req | input | 1 | A link training attempt is in progress |
| local_block | output | 1 | This side is blocking the link |
| global_block | output | 1 | Either side is blocking the link |
| partner_notify | output | 1 | One-cycle strobe: local_block changed, send it to the partner |
| link_down_req | output | 1 | Request to take an established link down |
| training_allowed | output | 1 | Link training may proceed |
| train_fail | output | 1 | The current training attempt must fail |

## Verification
A wrong state in the aggregator machine shows at local_block or global_block one cycle after the edge that set it, and in the same cycle at training_allowed, train_fail and link_down_req, which follow global_block without a register. A stuck software-disable latch shows as local_block staying high (or low) on the first cycle in which every other source is idle. A missed or extra state change is visible as a partner_notify strobe that is absent or appears when only the partner moved.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
    // Bit 1 = local side blocking, bit 0 = partner blocking.
    typedef enum logic [1:0] {
        LS_OPEN   = 2'b00,
        LS_REMOTE = 2'b01,
        LS_LOCAL  = 2'b10,
        LS_BOTH   = 2'b11
    } lbk_state_e;

    typedef enum logic {
        API_RUN  = 1'b0,
        API_HELD = 1'b1
    } api_state_e;
endpackage

// File: rtl/lbk_api_latch.sv
module lbk_api_latch
    import lbk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic api_disable,
    input  logic api_enable,
    output logic held_next
);
    api_state_e state_q;
    api_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            API_RUN:  if (api_disable) state_d = API_HELD;
            API_HELD: if (api_enable && !api_disable) state_d = API_RUN;
            default:  state_d = API_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= API_RUN;
        else        state_q <= state_d;
    end

    assign held_next = (state_d == API_HELD);
endmodule

// File: rtl/lbk_src_or.sv
module lbk_src_or #(
    parameter int NB = 4
) (
    input  logic          is_upstream,
    input  logic          link_disable,
    input  logic          api_held,
    input  logic [NB-1:0] custom_block,
    output logic          local_req
);
    localparam int CHAIN = NB + 2;

    logic [CHAIN-1:0] src;
    logic [CHAIN:0]   any;

    assign src[0] = link_disable & is_upstream;
    assign src[1] = api_held;

    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_custom
            assign src[g+2] = custom_block[g];
        end
        assign any[0] = 1'b0;
        for (g = 0; g < CHAIN; g++) begin : g_or
            assign any[g+1] = any[g] | src[g];
        end
    endgenerate

    assign local_req = any[CHAIN];
endmodule

// File: rtl/lbk_state_fsm.sv
module lbk_state_fsm
    import lbk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic local_req,
    input  logic partner_block,
    input  logic func_zero,
    output logic local_block,
    output logic global_block,
    output logic partner_notify
);
    lbk_state_e state_q;
    lbk_state_e state_d;
    logic       notify_q;
    logic       local_flip;

    // Next state: named by the new (local, partner) pair.
    always_comb begin
        unique case ({local_req, partner_block})
            2'b00:   state_d = LS_OPEN;
            2'b01:   state_d = LS_REMOTE;
            2'b10:   state_d = LS_LOCAL;
            2'b11:   state_d = LS_BOTH;
            default: state_d = LS_OPEN;
        endcase
    end

    // Does this transition move the local half of the state?
    always_comb begin
        unique case (state_q)
            LS_OPEN, LS_REMOTE: local_flip = (state_d == LS_LOCAL) || (state_d == LS_BOTH);
            LS_LOCAL, LS_BOTH:  local_flip = (state_d == LS_OPEN)  || (state_d == LS_REMOTE);
            default:            local_flip = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= LS_OPEN;
            notify_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            notify_q <= local_flip & func_zero;
        end
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            LS_OPEN:   begin local_block = 1'b0; global_block = 1'b0; end
            LS_REMOTE: begin local_block = 1'b0; global_block = 1'b1; end
            LS_LOCAL:  begin local_block = 1'b1; global_block = 1'b1; end
            LS_BOTH:   begin local_block = 1'b1; global_block = 1'b1; end
            default:   begin local_block = 1'b0; global_block = 1'b0; end
        endcase
    end

    assign partner_notify = notify_q;
endmodule

// File: rtl/link_block_agg.sv
module link_block_agg #(
    parameter int NB   = 4,
    parameter int FN_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            is_upstream,
    input  logic [FN_W-1:0] func_num,
    input  logic            link_disable,
    input  logic            api_disable,
    input  logic            api_enable,
    input  logic [NB-1:0]   custom_block,
    input  logic            partner_block,
    input  logic            link_up,
    input  logic            train_req,
    output logic            local_block,
    output logic            global_block,
    output logic            partner_notify,
    output logic            link_down_req,
    output logic            training_allowed,
    output logic            train_fail
);
    logic api_held;
    logic local_req;
    logic func_zero;

    assign func_zero = (func_num == '0);

    lbk_api_latch i_api (
        .clk         (clk),
        .rst_n       (rst_n),
        .api_disable (api_disable),
        .api_enable  (api_enable),
        .held_next   (api_held)
    );

    lbk_src_or #(.NB(NB)) i_src (
        .is_upstream  (is_upstream),
        .link_disable (link_disable),
        .api_held     (api_held),
        .custom_block (custom_block),
        .local_req    (local_req)
    );

    lbk_state_fsm i_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .local_req      (local_req),
        .partner_block  (partner_block),
        .func_zero      (func_zero),
        .local_block    (local_block),
        .global_block   (global_block),
        .partner_notify (partner_notify)
    );

    assign link_down_req    = global_block & link_up;
    assign training_allowed = ~global_block;
    assign train_fail       = train_req & global_block;
endmodule

// File: rtl/link_block_agg_chk.sv
module link_block_agg_chk #(
    parameter int NB   = 4,
    parameter int FN_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [FN_W-1:0] func_num,
    input logic            api_disable,
    input logic [NB-1:0]   custom_block,
    input logic            link_up,
    input logic            train_req,
    input logic            local_block,
    input logic            global_block,
    input logic            partner_notify,
    input logic            link_down_req,
    input logic            training_allowed,
    input logic            train_fail
);
    // R5: the global state always covers the local one
    a_r5_global_covers_local: assert property (@(posedge clk) disable iff (!rst_n)
        local_block |-> global_block);

    // R8: training gate opposes the global state
    a_r8_train_gate: assert property (@(posedge clk) disable iff (!rst_n)
        global_block |-> (!training_allowed && (train_fail == train_req)));

    // R7: an up link is asked to drop while blocked
    a_r7_link_down: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && global_block) |-> link_down_req);

    // R6: a notify strobe means local_block just moved
    a_r6_notify_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        partner_notify |-> (local_block != $past(local_block)));

    // R6: only function 0 notifies
    a_r6_notify_fn0: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(func_num) != '0) |-> !partner_notify);

    // R4: a disable request blocks on the next cycle
    a_r4_api_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(api_disable) |-> local_block);

    // R2: any custom condition blocks on the next cycle
    a_r2_custom_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(|custom_block) |-> local_block);
endmodule

bind link_block_agg link_block_agg_chk #(.NB(NB), .FN_W(FN_W)) i_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .func_num         (func_num),
    .api_disable      (api_disable),
    .custom_block     (custom_block),
    .link_up          (link_up),
    .train_req        (train_req),
    .local_block      (local_block),
    .global_block     (global_block),
    .partner_notify   (partner_notify),
    .link_down_req    (link_down_req),
    .training_allowed (training_allowed),
    .train_fail       (train_fail)
);

// File: tb/test_link_block_agg.sv
`timescale 1ns/1ps
module test_link_block_agg;
    localparam int NB   = 4;
    localparam int FN_W = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            is_upstream = 1'b0;
    logic [FN_W-1:0] func_num = '0;
    logic            link_disable = 1'b0;
    logic            api_disable = 1'b0;
    logic            api_enable = 1'b0;
    logic [NB-1:0]   custom_block = '0;
    logic            partner_block = 1'b0;
    logic            link_up = 1'b0;
    logic            train_req = 1'b0;
    logic            local_block, global_block, partner_notify;
    logic            link_down_req, training_allowed, train_fail;

    int n_chk = 0;
    int n_fail = 0;

    // reference state
    logic m_api = 1'b0;
    logic m_local = 1'b0;
    logic m_global = 1'b0;
    logic m_notify = 1'b0;
    logic m_part_only = 1'b0;

    always #2 clk = ~clk;

    link_block_agg #(.NB(NB), .FN_W(FN_W)) i_link_block_agg (
        .clk(clk), .rst_n(rst_n), .is_upstream(is_upstream), .func_num(func_num),
        .link_disable(link_disable), .api_disable(api_disable), .api_enable(api_enable),
        .custom_block(custom_block), .partner_block(partner_block), .link_up(link_up),
        .train_req(train_req), .local_block(local_block), .global_block(global_block),
        .partner_notify(partner_notify), .link_down_req(link_down_req),
        .training_allowed(training_allowed), .train_fail(train_fail)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // One clock edge: update the reference from the inputs held at the edge.
    task automatic step();
        logic api_n, loc_n, glob_n;
        @(posedge clk);
        api_n  = api_disable ? 1'b1 : (api_enable ? 1'b0 : m_api);
        loc_n  = (link_disable & is_upstream) | api_n | (|custom_block);
        glob_n = loc_n | partner_block;
        m_notify    = (loc_n != m_local) && (func_num == '0);
        m_part_only = (loc_n == m_local) && (glob_n != m_global);
        m_api    = api_n;
        m_local  = loc_n;
        m_global = glob_n;
        #1;
    endtask

    task automatic check_all();
        chk("R2/R3/R4 local_block", local_block, m_local);
        chk("R5 global_block", global_block, m_global);
        chk("R6 partner_notify", partner_notify, m_notify);
        if (m_part_only) chk("R9 no notify on partner change", partner_notify, 1'b0);
        chk("R7 link_down_req", link_down_req, m_global & link_up);
        chk("R8 training_allowed", training_allowed, ~m_global);
        chk("R8 train_fail", train_fail, train_req & m_global);
    endtask

    task automatic idle();
        is_upstream = 1'b0; link_disable = 1'b0; api_disable = 1'b0; api_enable = 1'b0;
        custom_block = '0; partner_block = 1'b0; func_num = '0;
    endtask

    initial begin
        #800000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        link_up = 1'b1; train_req = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 local_block", local_block, 1'b0);
        chk("R1 global_block", global_block, 1'b0);
        chk("R1 partner_notify", partner_notify, 1'b0);
        chk("R1 link_down_req", link_down_req, 1'b0);
        chk("R1 training_allowed", training_allowed, 1'b1);
        chk("R1 train_fail", train_fail, 1'b0);
        rst_n = 1'b1;
        step(); check_all();
        chk("R1 api released", local_block, 1'b0);

        // R4: latch, hold, release, simultaneous
        api_disable = 1'b1; step(); check_all(); api_disable = 1'b0;
        chk("R4 latched", local_block, 1'b1);
        repeat (3) begin step(); check_all(); end
        chk("R4 still held", local_block, 1'b1);
        api_enable = 1'b1; api_disable = 1'b1; step(); check_all();
        chk("R4 disable wins", local_block, 1'b1);
        api_disable = 1'b0; step(); check_all(); api_enable = 1'b0;
        chk("R4 released", local_block, 1'b0);

        // R3: link_disable gated by is_upstream
        link_disable = 1'b1; is_upstream = 1'b0; step(); check_all();
        chk("R3 downstream ignores", local_block, 1'b0);
        is_upstream = 1'b1; step(); check_all();
        chk("R3 upstream blocks", local_block, 1'b1);
        idle(); step(); check_all();

        // R9 / R7: partner alone, link up
        partner_block = 1'b1; step(); check_all();
        chk("R9 partner only notify", partner_notify, 1'b0);
        chk("R7 down with partner", link_down_req, 1'b1);
        idle(); step(); check_all();

        // Near-exhaustive sweep over 4096 scrambled input patterns
        for (int i = 0; i < 4096; i++) begin
            logic [11:0] v;
            v = 12'((i * 37 + 11) & 4095);
            custom_block  = v[3:0];
            is_upstream   = v[4];
            link_disable  = v[5];
            partner_block = v[6];
            func_num      = v[7] ? 3'd0 : 3'd5;
            link_up       = v[8];
            train_req     = v[9];
            api_disable   = v[10] & v[11] & v[0];
            api_enable    = v[11] & ~v[10];
            step();
            check_all();
            // hold one quiet cycle to expose release and notify on function 0
            if (v[2:0] == 3'b000) begin
                idle(); func_num = v[7] ? 3'd0 : 3'd2;
                step(); check_all();
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule